// File: doc/BRIEF.md
# Address Match Debug Trigger Bank

This block holds a small set of hardware debug triggers for a processor core. Each trigger carries a control word and a compare word. When a trigger is armed, it watches either the instruction fetch address or the address of a data load or store. On an exact match it asks the core to take a breakpoint exception before the matching instruction or access completes. The core supplies the fetch address, the data access address and its direction, the current privilege level and whether guest (virtualized) execution is active. The breakpoint request is combinational, so the core can cancel the access in the same cycle.

Software programs the bank through one register port. It first picks a trigger with the index register, then reads or writes that trigger's control, compare and auxiliary words. A read-only capability word lists the two layouts that are supported. Two control layouts exist. The host layout (type 2) is qualified by the user, supervisor and machine enables only, and it never fires in guest mode. The extended layout (type 6) adds guest-user and guest-supervisor enables. A control write is legalized before it is stored: fields that are not implemented are cleared, and size codes that are not supported become "any size".

Top module: `dbg_trig_bank`

## Requirements
- R1: Register codes on `csr_sel` are 0 index, 1 control, 2 compare, 3 auxiliary and 4 capability. A write to the index takes effect only when the value is below NUM_TRIG, and otherwise leaves the index unchanged. Reading the index returns it zero-extended. Codes 5 to 7 read zero, and writes to them have no effect.
- R2: After reset the index is 0, every control word holds type 2 with all other bits zero (0x2000_0000 for XLEN=32), and every compare word is zero.
- R3: A control write whose type field (bits XLEN-1:XLEN-4) is neither 2 nor 6 is ignored, and the selected control word keeps its value.
- R4: An accepted control write keeps only these fields: type, load (bit 0), store (bit 1), execute (bit 2), user (bit 3), supervisor (bit 4), machine (bit 6) and the size field. Type 6 also keeps guest-user (bit 23) and guest-supervisor (bit 24). Every other bit, including the debug-only flag at bit XLEN-5, reads zero.
- R5: The type 2 size field is bits 17:16, with bits 22:21 as its upper pair on 64-bit cores. The type 6 size field is bits 19:16. Size codes 0, 1, 2, 3 and 5 are stored as written, and any other code is stored as 0.
- R6: The auxiliary word always reads zero and writes to it are discarded. The capability word reads 0x44 (bits 2 and 6) and cannot be written.
- R7: With `fetch_vld` high, a trigger whose execute bit is set and whose compare word equals `fetch_pc` raises `brk_req` in the same cycle, provided its privilege check passes.
- R8: With `mem_vld` high, a trigger whose compare word equals `mem_addr` raises `brk_req` in the same cycle when the load bit is set and `mem_store` is 0, or when the store bit is set and `mem_store` is 1, provided its privilege check passes.
- R9: Privilege codes are 0 user, 1 supervisor and 3 machine. Outside guest mode, the privilege check passes when bit 3+`priv` of the control word is set. Code 2 never passes. A type 2 trigger never fires while `virt` is 1.
- R10: With `virt` at 1, a type 6 trigger passes its privilege check only when `priv` is 0 and bit 23 is set, or when `priv` is 1 and bit 24 is set.
- R11: A trigger with no privilege enable set, or with none of load, store or execute set, never fires. A compare mismatch never fires.
- R12: When several triggers hit in one cycle, `brk_idx` gives the lowest index. `brk_idx` is 0 whenever `brk_req` is low.
- R13: Control and compare writes change only the trigger named by the index register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_sel | input | 3 | Register code (see R1) |
| csr_wdata | input | XLEN | Register write data |
| csr_rdata | output | XLEN | Register read data, combinational from `csr_sel` |
| fetch_vld | input | 1 | Fetch address is valid this cycle |
| fetch_pc | input | XLEN | Instruction fetch address |
| mem_vld | input | 1 | Data access is valid this cycle |
| mem_store | input | 1 | 1 for a store, 0 for a load |
| mem_addr | input | XLEN | Data access address |
| priv | input | 2 | Current privilege level |
| virt | input | 1 | Guest execution active |
| brk_req | output | 1 | Breakpoint request |
| brk_idx | output | IDXW | Index of the lowest hitting trigger |

## Verification
A trigger whose stored control or compare word is wrong shows at the ports in two ways. Its control or compare readback differs on the very next read. `brk_req` also fires or stays silent in the same cycle the matching address is presented. The sweeps therefore read back each word right after it is written. They then present every combination of layout, privilege enables, access kind, privilege level and guest flag, and compare the combinational request in that cycle. An index register that drifts shows up as a write landing in the wrong trigger, or as a wrong `brk_idx` in the priority checks.

// File: rtl/dbg_trig_pkg.sv
// Shared register codes, layout codes and helpers for the debug trigger bank.
// Assumes control words are at least 32 bits wide.
package dbg_trig_pkg;

    typedef enum logic [2:0] {
        REG_INDEX = 3'd0,
        REG_CTRL  = 3'd1,
        REG_CMP   = 3'd2,
        REG_AUX   = 3'd3,
        REG_CAPS  = 3'd4
    } csr_reg_e;

    localparam logic [3:0] LAYOUT_HOST = 4'd2;
    localparam logic [3:0] LAYOUT_EXT  = 4'd6;

    localparam int BIT_LOAD  = 0;
    localparam int BIT_STORE = 1;
    localparam int BIT_EXEC  = 2;
    localparam int BIT_HPRIV = 3;
    localparam int BIT_GPRIV = 23;

    // Size codes that stay as written: any, 1, 2, 4 and 8 bytes.
    function automatic logic size_code_ok(input logic [3:0] code);
        return (code <= 4'd3) || (code == 4'd5);
    endfunction

endpackage

// File: rtl/dbg_trig_slot.sv
// One address-match trigger: holds the legalized control word and the compare
// word, and flags a same-cycle hit on a fetch or a data access.
// Assumes the caller decodes the register port and steers the write enables.
module dbg_trig_slot
    import dbg_trig_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_we,
    input  logic            cmp_we,
    input  logic [XLEN-1:0] wdata,
    input  logic            fetch_vld,
    input  logic [XLEN-1:0] fetch_pc,
    input  logic            mem_vld,
    input  logic            mem_store,
    input  logic [XLEN-1:0] mem_addr,
    input  logic [1:0]      priv,
    input  logic            virt,
    output logic [XLEN-1:0] ctrl_q,
    output logic [XLEN-1:0] cmp_q,
    output logic            hit
);

    localparam logic [XLEN-1:0] TYPE_MASK = {4'hF, {(XLEN-4){1'b0}}};
    localparam logic [XLEN-1:0] BASE_KEEP = TYPE_MASK | XLEN'(32'h0000_005F);
    localparam logic [XLEN-1:0] SIZE2_HI  = (XLEN > 32) ? XLEN'(32'h0060_0000) : '0;
    localparam logic [XLEN-1:0] KEEP_HOST = BASE_KEEP | XLEN'(32'h0003_0000) | SIZE2_HI;
    localparam logic [XLEN-1:0] KEEP_EXT  = BASE_KEEP | XLEN'(32'h018F_0000);
    localparam logic [XLEN-1:0] RESET_CTRL = {LAYOUT_HOST, {(XLEN-4){1'b0}}};

    logic [3:0]      wr_type;
    logic            wr_is_ext;
    logic            wr_accept;
    logic [XLEN-1:0] wr_masked;
    logic [XLEN-1:0] wr_legal;
    logic            is_ext;
    logic            priv_ok;
    logic            exec_hit;
    logic            data_hit;

    // Purpose: clear unimplemented fields and unsupported size codes of a write.
    always_comb begin
        wr_type   = wdata[XLEN-1 -: 4];
        wr_is_ext = (wr_type == LAYOUT_EXT);
        wr_accept = (wr_type == LAYOUT_HOST) || wr_is_ext;
        wr_masked = wdata & (wr_is_ext ? KEEP_EXT : KEEP_HOST);
        wr_legal  = wr_masked;
        if (wr_is_ext) begin
            if (!size_code_ok(wr_masked[19:16])) begin
                wr_legal[19:16] = 4'd0;
            end
        end else if (!size_code_ok({wr_masked[22:21], wr_masked[17:16]})) begin
            wr_legal[22:21] = 2'd0;
            wr_legal[17:16] = 2'd0;
        end
    end

    // Purpose: hold the control word; writes of unsupported layouts are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= RESET_CTRL;
        end else if (ctrl_we && wr_accept) begin
            ctrl_q <= wr_legal;
        end
    end

    // Purpose: hold the compare address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_we) begin
            cmp_q <= wdata;
        end
    end

    // Purpose: decide whether the current privilege and guest state enable this trigger.
    always_comb begin
        is_ext  = (ctrl_q[XLEN-1 -: 4] == LAYOUT_EXT);
        priv_ok = 1'b0;
        if (virt) begin
            if (is_ext) begin
                case (priv)
                    2'd0:    priv_ok = ctrl_q[BIT_GPRIV];
                    2'd1:    priv_ok = ctrl_q[BIT_GPRIV + 1];
                    default: priv_ok = 1'b0;
                endcase
            end
        end else begin
            case (priv)
                2'd0:    priv_ok = ctrl_q[BIT_HPRIV];
                2'd1:    priv_ok = ctrl_q[BIT_HPRIV + 1];
                2'd3:    priv_ok = ctrl_q[BIT_HPRIV + 3];
                default: priv_ok = 1'b0;
            endcase
        end
    end

    // Purpose: compare fetch and data addresses against the compare word.
    always_comb begin
        exec_hit = fetch_vld && ctrl_q[BIT_EXEC] && (fetch_pc == cmp_q);
        data_hit = mem_vld && (mem_addr == cmp_q) &&
                   (mem_store ? ctrl_q[BIT_STORE] : ctrl_q[BIT_LOAD]);
        hit      = priv_ok && (exec_hit || data_hit);
    end

endmodule

// File: rtl/dbg_trig_prio.sv
// Fixed-priority picker: reports whether any trigger hit and the lowest index.
// Assumes IW is wide enough to hold N-1.
module dbg_trig_prio #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  hits,
    output logic          any_hit,
    output logic [IW-1:0] first_idx
);

    // Purpose: scan from the top so the lowest set index is the one kept.
    always_comb begin
        any_hit   = |hits;
        first_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                first_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/dbg_trig_bank.sv
// Debug trigger bank: index register, a row of address-match triggers, the
// register read mux and the breakpoint priority picker.
// Assumes single-cycle register access with combinational read data.
module dbg_trig_bank
    import dbg_trig_pkg::*;
#(
    parameter  int XLEN     = 32,
    parameter  int NUM_TRIG = 4,
    localparam int IDXW     = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_wr,
    input  logic [2:0]      csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    input  logic            fetch_vld,
    input  logic [XLEN-1:0] fetch_pc,
    input  logic            mem_vld,
    input  logic            mem_store,
    input  logic [XLEN-1:0] mem_addr,
    input  logic [1:0]      priv,
    input  logic            virt,
    output logic            brk_req,
    output logic [IDXW-1:0] brk_idx
);

    localparam logic [XLEN-1:0] CAPS_WORD = XLEN'((1 << LAYOUT_HOST) | (1 << LAYOUT_EXT));

    logic [IDXW-1:0]     sel_q;
    logic [NUM_TRIG-1:0] hit_vec;
    logic [XLEN-1:0]     ctrl_arr [NUM_TRIG];
    logic [XLEN-1:0]     cmp_arr  [NUM_TRIG];
    logic                wr_ctrl;
    logic                wr_cmp;

    assign wr_ctrl = csr_wr && (csr_sel == REG_CTRL);
    assign wr_cmp  = csr_wr && (csr_sel == REG_CMP);

    // Purpose: hold the selected trigger index, ignoring out-of-range writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (csr_wr && (csr_sel == REG_INDEX) && (csr_wdata < XLEN'(NUM_TRIG))) begin
            sel_q <= csr_wdata[IDXW-1:0];
        end
    end

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
        dbg_trig_slot #(.XLEN(XLEN)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl_we   (wr_ctrl && (sel_q == IDXW'(g))),
            .cmp_we    (wr_cmp && (sel_q == IDXW'(g))),
            .wdata     (csr_wdata),
            .fetch_vld (fetch_vld),
            .fetch_pc  (fetch_pc),
            .mem_vld   (mem_vld),
            .mem_store (mem_store),
            .mem_addr  (mem_addr),
            .priv      (priv),
            .virt      (virt),
            .ctrl_q    (ctrl_arr[g]),
            .cmp_q     (cmp_arr[g]),
            .hit       (hit_vec[g])
        );
    end

    dbg_trig_prio #(.N(NUM_TRIG), .IW(IDXW)) u_prio (
        .hits      (hit_vec),
        .any_hit   (brk_req),
        .first_idx (brk_idx)
    );

    // Purpose: return the addressed register word.
    always_comb begin
        case (csr_sel)
            REG_INDEX: csr_rdata = XLEN'(sel_q);
            REG_CTRL:  csr_rdata = ctrl_arr[sel_q];
            REG_CMP:   csr_rdata = cmp_arr[sel_q];
            REG_CAPS:  csr_rdata = CAPS_WORD;
            default:   csr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dbg_trig_bank_chk.sv
// Property checker for the debug trigger bank, bound to every instance.
// Assumes the register codes of dbg_trig_pkg.
module dbg_trig_bank_chk
    import dbg_trig_pkg::*;
#(
    parameter  int XLEN     = 32,
    parameter  int NUM_TRIG = 4,
    localparam int IDXW     = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            csr_wr,
    input logic [2:0]      csr_sel,
    input logic [XLEN-1:0] csr_rdata,
    input logic [IDXW-1:0] sel_q,
    input logic            fetch_vld,
    input logic            mem_vld,
    input logic            brk_req,
    input logic [IDXW-1:0] brk_idx
);

    // R1: the index read back never leaves the implemented range.
    a_r1_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_sel == REG_INDEX) |-> (csr_rdata < XLEN'(NUM_TRIG)));

    // R1: the index holds when it is not written.
    a_r1_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_wr && (csr_sel == REG_INDEX)) |=> $stable(sel_q));

    // R4: a stored control word never shows the debug-only flag or an unsupported layout.
    a_r4_ctrl_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_sel == REG_CTRL) |-> (!csr_rdata[XLEN-5] &&
            ((csr_rdata[XLEN-1 -: 4] == LAYOUT_HOST) || (csr_rdata[XLEN-1 -: 4] == LAYOUT_EXT))));

    // R6: the auxiliary word reads zero.
    a_r6_aux_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_sel == REG_AUX) |-> (csr_rdata == '0));

    // R6: the capability word lists exactly the two layouts.
    a_r6_caps: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_sel == REG_CAPS) |-> (csr_rdata == XLEN'(32'h44)));

    // R11: no breakpoint without a valid fetch or data access.
    a_r11_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (fetch_vld || mem_vld));

    // R12: the reported index is zero while no breakpoint is requested.
    a_r12_idx_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_req |-> (brk_idx == '0));

endmodule

bind dbg_trig_bank dbg_trig_bank_chk #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (csr_wr),
    .csr_sel   (csr_sel),
    .csr_rdata (csr_rdata),
    .sel_q     (sel_q),
    .fetch_vld (fetch_vld),
    .mem_vld   (mem_vld),
    .brk_req   (brk_req),
    .brk_idx   (brk_idx)
);

// File: tb/test_dbg_trig_bank.sv
// Self-checking sweep bench for dbg_trig_bank at XLEN=32, four triggers.
module test_dbg_trig_bank;

    localparam int XLEN = 32;
    localparam int NT   = 4;
    localparam int IW   = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_wr = 1'b0;
    logic [2:0]      csr_sel = 3'd0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            fetch_vld = 1'b0;
    logic [XLEN-1:0] fetch_pc = '0;
    logic            mem_vld = 1'b0;
    logic            mem_store = 1'b0;
    logic [XLEN-1:0] mem_addr = '0;
    logic [1:0]      priv = 2'd3;
    logic            virt = 1'b0;
    logic            brk_req;
    logic [IW-1:0]   brk_idx;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dbg_trig_bank #(.XLEN(XLEN), .NUM_TRIG(NT)) i_dbg_trig_bank (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .fetch_vld(fetch_vld),
        .fetch_pc(fetch_pc), .mem_vld(mem_vld), .mem_store(mem_store),
        .mem_addr(mem_addr), .priv(priv), .virt(virt), .brk_req(brk_req),
        .brk_idx(brk_idx)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_sel = s; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] d);
        csr_sel = s;
        #1;
        d = csr_rdata;
    endtask

    // Expected stored control word for an accepted write (R4, R5).
    function automatic logic [31:0] exp_ctrl(input logic [31:0] w);
        logic [31:0] r = '0;
        logic [3:0]  sz;
        r[31:28] = w[31:28];
        r[4:0]   = w[4:0];
        r[6]     = w[6];
        if (w[31:28] == 4'd6) begin
            sz = w[19:16];
            r[19:16] = (sz <= 4'd3 || sz == 4'd5) ? sz : 4'd0;
            r[24:23] = w[24:23];
        end else begin
            r[17:16] = w[17:16];
        end
        return r;
    endfunction

    // Expected hit from layout, enables (U,S,M,VU,VS), kinds (L,S,X) and state.
    function automatic bit exp_hit(input int ty, input int pm, input int km,
                                   input int vt, input int pv, input int a);
        bit kind;
        bit en;
        kind = (a == 0) ? km[2] : (a == 1) ? km[0] : km[1];
        if (vt != 0) en = (ty == 6) && ((pv == 0 && pm[3]) || (pv == 1 && pm[4]));
        else         en = (pv == 0 && pm[0]) || (pv == 1 && pm[1]) || (pv == 3 && pm[2]);
        return kind && en;
    endfunction

    task automatic drive_access(input int a, input logic [31:0] addr);
        fetch_vld = (a == 0);
        fetch_pc  = addr;
        mem_vld   = (a != 0);
        mem_store = (a == 2);
        mem_addr  = addr;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] prev;
        logic [31:0] w;
        int cur;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state of index, control and compare words.
        rd(3'd0, d); chk("R2 index", d, 0);
        for (int t = 0; t < NT; t++) begin
            wr(3'd0, t);
            rd(3'd1, d); chk("R2 ctrl", d, 32'h2000_0000);
            rd(3'd2, d); chk("R2 cmp", d, 0);
        end

        // R1: index writes in and out of range.
        cur = NT - 1;
        for (int v = 0; v < 8; v++) begin
            wr(3'd0, v);
            if (v < NT) cur = v;
            rd(3'd0, d); chk("R1 index", d, cur);
        end
        wr(3'd0, 32'hFFFF_FFF0);
        rd(3'd0, d); chk("R1 huge index ignored", d, cur);

        // R13: compare writes land only in the selected trigger.
        for (int t = 0; t < NT; t++) begin
            wr(3'd0, t);
            wr(3'd2, 32'h1000 + t * 16);
        end
        for (int t = 0; t < NT; t++) begin
            wr(3'd0, t);
            rd(3'd2, d); chk("R13 cmp", d, 32'h1000 + t * 16);
            rd(3'd1, d); chk("R13 ctrl untouched", d, 32'h2000_0000);
        end

        // R3, R4, R5: control legalization sweep on trigger 1.
        wr(3'd0, 1);
        prev = 32'h2000_0000;
        for (int t = 0; t < 16; t++) begin
            for (int s = 0; s < 16; s++) begin
                for (int p = 0; p < 2; p++) begin
                    w = (p == 0) ? {t[3:0], 8'hFF, s[3:0], 16'hFFFF}
                                 : {t[3:0], 8'h00, s[3:0], 16'h0000};
                    wr(3'd1, w);
                    if (t == 2 || t == 6) prev = exp_ctrl(w);
                    rd(3'd1, d);
                    chk((t != 2 && t != 6) ? "R3 ctrl" : (t == 6) ? "R5 ctrl" : "R4 ctrl", d, prev);
                end
            end
        end
        wr(3'd1, 32'h2000_0000);

        // R6: auxiliary and capability words, unused codes.
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, d); chk("R6 aux", d, 0);
        rd(3'd2, d); chk("R6 aux write no effect", d, 32'h1010);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, d); chk("R6 caps", d, 32'h44);
        for (int c = 5; c < 8; c++) begin
            wr(c[2:0], 32'hFFFF_FFFF);
            rd(c[2:0], d); chk("R1 unused code", d, 0);
        end
        rd(3'd0, d); chk("R1 index after unused", d, 1);

        // R7-R11: match sweep on trigger 2 (compare 0x1020).
        wr(3'd0, 2);
        for (int ty = 2; ty <= 6; ty += 4) begin
            for (int pm = 0; pm < 32; pm++) begin
                for (int km = 0; km < 8; km++) begin
                    w = (ty << 28) | km | (pm[0] << 3) | (pm[1] << 4) | (pm[2] << 6) |
                        (pm[3] << 23) | (pm[4] << 24);
                    wr(3'd1, w);
                    for (int vt = 0; vt < 2; vt++) begin
                        for (int pv = 0; pv < 4; pv++) begin
                            for (int a = 0; a < 3; a++) begin
                                virt = vt[0];
                                priv = pv[1:0];
                                drive_access(a, 32'h1020);
                                #1;
                                chk(a == 0 ? "R7 R9 R10 exec" : "R8 R9 R10 data", brk_req,
                                    exp_hit(ty, pm, km, vt, pv, a));
                                chk("R12 idx", brk_idx, exp_hit(ty, pm, km, vt, pv, a) ? 2 : 0);
                            end
                        end
                    end
                    virt = 1'b0; priv = 2'd3;
                    for (int a = 0; a < 3; a++) begin
                        drive_access(a, 32'h1021);
                        #1;
                        chk("R11 mismatch", brk_req, 0);
                    end
                    fetch_vld = 1'b0; mem_vld = 1'b0;
                end
            end
        end
        wr(3'd1, 32'h2000_0000);

        // R7, R13: each trigger matches only its own compare word.
        for (int t = 0; t < NT; t++) begin
            wr(3'd0, t);
            wr(3'd1, 32'h2000_0044);
        end
        for (int t = 0; t < NT; t++) begin
            drive_access(0, 32'h1000 + t * 16);
            #1;
            chk("R7 own address", brk_req, 1);
            chk("R12 own index", brk_idx, t);
        end
        fetch_vld = 1'b0;

        // R12: priority among simultaneous hits.
        for (int t = 0; t < NT; t++) begin
            wr(3'd0, t);
            wr(3'd2, 32'h4000);
        end
        for (int k = 0; k <= NT; k++) begin
            drive_access(0, 32'h4000);
            #1;
            chk("R12 req", brk_req, k < NT);
            chk("R12 lowest", brk_idx, (k < NT) ? k : 0);
            fetch_vld = 1'b0;
            if (k < NT) begin
                wr(3'd0, k);
                wr(3'd1, 32'h2000_0000);
            end
        end

        summary();
        $finish;
    end

endmodule